// File: doc/BRIEF.md
# Low-Power Mode and Reset Controller

This block sits beside a small 8-bit processor core. It decides when the core, the peripherals and the oscillator are clocked, and when the core is put into reset. A flip-flop halves the raw oscillator clock. All enables are produced at that halved rate, one pulse every two oscillator periods, so the duty cycle of the incoming clock plays no part. The block also keeps a state counter that other logic can use to find its place inside a machine cycle. A machine cycle is six states of two phases each, which is twelve oscillator periods.

Software enters a low-power mode by strobing a request. Idle stops only the processor: peripherals, interrupt logic and memory keep running, and any pending interrupt or a reset pin event brings the core back. Power-down freezes everything, including the timebase, and only the reset pin can leave it. Once the pin rises, the oscillator restarts with the processor held stopped. The reset pin is accepted only after it has been high through two complete machine cycles, and any low sample restarts that count. When a reset pin event ends idle, the processor resumes for the short window before the qualified reset takes over. During that window a guard output blocks writes to internal RAM.

Top module: `lpm_rst_ctrl`

## Requirements
- R1: While the oscillator runs, `phase_o` toggles on every oscillator edge. `cpu_clk_en` and `per_clk_en` are only ever high while `phase_o` is 1.
- R2: `state_o` counts 0 to 5 and advances on each edge where `phase_o` is 1, so one machine cycle spans 12 oscillator periods. Both counters read 0 in the reset state.
- R3: In idle, `cpu_clk_en` stays low, while `per_clk_en` keeps pulsing and `osc_run` stays high.
- R4: A high `irq_pending` in idle returns the block to normal running on the next edge. `irq_pending` has no effect in any other mode.
- R5: In power-down, `osc_run` is low and `phase_o` and `state_o` hold their values. `irq_pending` does not wake the block.
- R6: Power-down is left only when the synchronised reset pin is high. The oscillator then restarts with `cpu_clk_en` held low. If the pin falls before the reset is qualified, the block returns to power-down.
- R7: `core_rst` rises only after the synchronised reset pin has been high through two full machine cycles that each end where `state_o`=5 and `phase_o`=1. Any low sample clears the count and drops `core_rst` on the next edge. On the edge after `core_rst` is high, the block is running and the RAM guard is clear.
- R8: When a reset pin event ends idle, the processor clock resumes and `ram_wr_block` goes high. The guard stays high until `core_rst` rises or the pin falls.
- R9: Requests raised in the same cycle enter power-down. A power-down request during idle is ignored. Requests are ignored while `core_rst` is high.
- R10: A request strobe seen on an edge while running changes the mode on that same edge. `pd_set` clears `osc_run`; `idle_set` clears `cpu_clk_en` while `per_clk_en` keeps pulsing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | External reset pin, active high, unsynchronised |
| idle_set | input | 1 | One-cycle software request for idle |
| pd_set | input | 1 | One-cycle software request for power-down |
| irq_pending | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | Processor clock enable, one pulse per two oscillator periods |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable, low in power-down |
| core_rst | output | 1 | Qualified synchronous core reset |
| ram_wr_block | output | 1 | Blocks internal RAM writes after idle ends by reset |
| phase_o | output | 1 | Phase within the current state |
| state_o | output | 3 | State index within the machine cycle |

## Verification
The properties assume that `idle_set`, `pd_set`, `irq_pending` and `rst_pin` change only away from the oscillator edge. They also assume that the oscillator clock keeps running in simulation even while `osc_run` is low, because the freeze is modelled by gating the counters. The stimulus drives every input on the falling edge of the clock. Request strobes last exactly one cycle. Reset pin pulses are deliberately made shorter than, exactly around, and longer than the two-machine-cycle window, and one glitch is placed inside a long high period, so that the qualifier restart is exercised.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      MODE_RUN   = 2'd0,
      MODE_IDLE  = 2'd1,
      MODE_PDOWN = 2'd2,
      MODE_WAKE  = 2'd3
   } lpm_mode_e;
endpackage

// File: rtl/lpm_timebase.sv
module lpm_timebase #(
   parameter int STATES = 6,
   localparam int SW = $clog2(STATES)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          run_i,
   output logic          phase_o,
   output logic [SW-1:0] state_o,
   output logic          cycle_end_o
);
   localparam logic [SW-1:0] LAST = SW'(STATES - 1);

   initial begin
      assert (STATES >= 2) else $error("STATES must be at least 2");
   end

   logic          phase_q;
   logic [SW-1:0] state_q;

   // divide-by-two phase flop, frozen when the oscillator is stopped
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         phase_q <= 1'b0;
         state_q <= '0;
      end else if (run_i) begin
         phase_q <= ~phase_q;
         if (phase_q) state_q <= (state_q == LAST) ? '0 : state_q + 1'b1;
      end
   end

   assign phase_o     = phase_q;
   assign state_o     = state_q;
   assign cycle_end_o = run_i && phase_q && (state_q == LAST);
endmodule

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
   parameter int SYNC_STAGES = 1,
   parameter int HOLD_CYCLES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_pin,
   input  logic cycle_end_i,
   output logic rst_level_o,
   output logic core_rst_o
);
   localparam int CW = $clog2(HOLD_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

   initial begin
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (HOLD_CYCLES >= 1) else $error("HOLD_CYCLES must be at least 1");
   end

   logic pin_s;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) s_q <= 1'b0;
            else        s_q <= rst_pin;
         end
         assign pin_s = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) s_q <= '0;
            else        s_q <= {s_q[SYNC_STAGES-2:0], rst_pin};
         end
         assign pin_s = s_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          armed_q;
   logic          core_q;

   // armed: pin was high at the start of the current machine cycle
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         core_q  <= 1'b1;
      end else if (!pin_s) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         core_q  <= 1'b0;
      end else if (cycle_end_i) begin
         armed_q <= 1'b1;
         if (armed_q && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LIMIT - 1'b1) core_q <= 1'b1;
         end
      end
   end

   assign rst_level_o = pin_s;
   assign core_rst_o  = core_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic      clk,
   input  logic      por_n,
   input  logic      core_rst_i,
   input  logic      rst_level_i,
   input  logic      idle_set_i,
   input  logic      pd_set_i,
   input  logic      irq_i,
   output lpm_mode_e mode_o,
   output logic      guard_o
);
   lpm_mode_e mode_q, mode_d;
   logic      guard_q, guard_d;

   always_comb begin
      mode_d  = mode_q;
      guard_d = guard_q && rst_level_i;
      if (core_rst_i) begin
         mode_d  = MODE_RUN;
         guard_d = 1'b0;
      end else begin
         unique case (mode_q)
            MODE_RUN: begin
               if (pd_set_i)        mode_d = MODE_PDOWN;
               else if (idle_set_i) mode_d = MODE_IDLE;
            end
            MODE_IDLE: begin
               if (rst_level_i) begin
                  mode_d  = MODE_RUN;
                  guard_d = 1'b1;
               end else if (irq_i) begin
                  mode_d = MODE_RUN;
               end
            end
            MODE_PDOWN: if (rst_level_i)  mode_d = MODE_WAKE;
            MODE_WAKE:  if (!rst_level_i) mode_d = MODE_PDOWN;
            default:    mode_d = MODE_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode_q  <= MODE_RUN;
         guard_q <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         guard_q <= guard_d;
      end
   end

   assign mode_o  = mode_q;
   assign guard_o = guard_q;
endmodule

// File: rtl/lpm_rst_ctrl.sv
module lpm_rst_ctrl
   import lpm_pkg::*;
#(
   parameter int STATES      = 6,
   parameter int SYNC_STAGES = 1,
   parameter int HOLD_CYCLES = 2,
   localparam int SW = $clog2(STATES)
) (
   input  logic          osc_clk,
   input  logic          por_n,
   input  logic          rst_pin,
   input  logic          idle_set,
   input  logic          pd_set,
   input  logic          irq_pending,
   output logic          cpu_clk_en,
   output logic          per_clk_en,
   output logic          osc_run,
   output logic          core_rst,
   output logic          ram_wr_block,
   output logic          phase_o,
   output logic [SW-1:0] state_o
);
   lpm_mode_e mode;
   logic      cycle_end;
   logic      rst_level;

   assign osc_run = (mode != MODE_PDOWN);

   lpm_timebase #(.STATES(STATES)) tb_i (
      .clk(osc_clk), .por_n(por_n), .run_i(osc_run),
      .phase_o(phase_o), .state_o(state_o), .cycle_end_o(cycle_end)
   );

   lpm_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) rq_i (
      .clk(osc_clk), .por_n(por_n), .rst_pin(rst_pin),
      .cycle_end_i(cycle_end), .rst_level_o(rst_level), .core_rst_o(core_rst)
   );

   lpm_mode_fsm fsm_i (
      .clk(osc_clk), .por_n(por_n), .core_rst_i(core_rst),
      .rst_level_i(rst_level), .idle_set_i(idle_set), .pd_set_i(pd_set),
      .irq_i(irq_pending), .mode_o(mode), .guard_o(ram_wr_block)
   );

   assign cpu_clk_en = (mode == MODE_RUN) && phase_o;
   assign per_clk_en = ((mode == MODE_RUN) || (mode == MODE_IDLE)) && phase_o;
endmodule

// File: rtl/lpm_rst_ctrl_chk.sv
module lpm_rst_ctrl_chk #(
   parameter int SW = 3
) (
   input logic          osc_clk,
   input logic          por_n,
   input logic          cpu_clk_en,
   input logic          per_clk_en,
   input logic          osc_run,
   input logic          core_rst,
   input logic          ram_wr_block,
   input logic          phase_o,
   input logic [SW-1:0] state_o,
   input logic          rst_q
);
   AST_PHASE_TOGGLES: assert property (@(posedge osc_clk) disable iff (!por_n)
      osc_run |=> phase_o != $past(phase_o));                             // R1
   AST_CPU_NEEDS_PERIPH: assert property (@(posedge osc_clk) disable iff (!por_n)
      cpu_clk_en |-> per_clk_en && osc_run);                              // R3
   AST_FROZEN_IN_PDOWN: assert property (@(posedge osc_clk) disable iff (!por_n)
      !osc_run |=> $stable(state_o) && $stable(phase_o));                 // R5
   AST_WAKE_BY_PIN: assert property (@(posedge osc_clk) disable iff (!por_n)
      $rose(osc_run) |-> $past(rst_q));                                   // R6
   AST_RST_NEEDS_PIN: assert property (@(posedge osc_clk) disable iff (!por_n)
      $rose(core_rst) |-> $past(rst_q));                                  // R7
   AST_RST_RUNS: assert property (@(posedge osc_clk) disable iff (!por_n)
      core_rst |=> osc_run && !ram_wr_block);                             // R7
   AST_GUARD_PIN: assert property (@(posedge osc_clk) disable iff (!por_n)
      ram_wr_block |-> $past(rst_q));                                     // R8
endmodule

bind lpm_rst_ctrl lpm_rst_ctrl_chk #(.SW(SW)) chk_i (
   .osc_clk(osc_clk), .por_n(por_n), .cpu_clk_en(cpu_clk_en),
   .per_clk_en(per_clk_en), .osc_run(osc_run), .core_rst(core_rst),
   .ram_wr_block(ram_wr_block), .phase_o(phase_o), .state_o(state_o),
   .rst_q(rst_level)
);

// File: tb/lpm_rst_ctrl_tb_top.sv
module lpm_rst_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic osc_clk = 1'b0;
   logic por_n = 1'b0, rst_pin = 1'b0, idle_set = 1'b0, pd_set = 1'b0, irq_pending = 1'b0;
   logic cpu_clk_en, per_clk_en, osc_run, core_rst, ram_wr_block, phase_o;
   logic [2:0] state_o;

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

   lpm_rst_ctrl dut_i (
      .osc_clk(osc_clk), .por_n(por_n), .rst_pin(rst_pin), .idle_set(idle_set),
      .pd_set(pd_set), .irq_pending(irq_pending), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_run(osc_run), .core_rst(core_rst),
      .ram_wr_block(ram_wr_block), .phase_o(phase_o), .state_o(state_o)
   );

   // behavioural reference: 0 run, 1 idle, 2 power-down, 3 waking
   int m_mode = 0, m_phase = 0, m_state = 0, m_cnt = 0;
   bit m_pin = 0, m_armed = 0, m_core = 1, m_guard = 0;

   always @(posedge osc_clk or negedge por_n) begin
      if (!por_n) begin
         m_mode = 0; m_phase = 0; m_state = 0; m_cnt = 0;
         m_pin = 0; m_armed = 0; m_core = 1; m_guard = 0;
      end else begin
         bit running, boundary, n_core, n_armed, n_guard;
         int n_mode, n_cnt;
         running  = (m_mode != 2);
         boundary = running && m_phase == 1 && m_state == 5;
         n_core = m_core; n_armed = m_armed; n_cnt = m_cnt;
         if (!m_pin) begin n_core = 0; n_armed = 0; n_cnt = 0; end
         else if (boundary) begin
            n_armed = 1;
            if (m_armed && m_cnt < 2) begin
               n_cnt = m_cnt + 1;
               if (n_cnt == 2) n_core = 1;
            end
         end
         n_mode = m_mode; n_guard = m_guard && m_pin;
         if (m_core) begin n_mode = 0; n_guard = 0; end
         else if (m_mode == 0) begin
            if (pd_set) n_mode = 2; else if (idle_set) n_mode = 1;
         end else if (m_mode == 1) begin
            if (m_pin) begin n_mode = 0; n_guard = 1; end
            else if (irq_pending) n_mode = 0;
         end else if (m_mode == 2) begin
            if (m_pin) n_mode = 3;
         end else if (!m_pin) n_mode = 2;
         if (running) begin
            if (m_phase == 1) m_state = (m_state + 1) % 6;
            m_phase = 1 - m_phase;
         end
         m_core = n_core; m_armed = n_armed; m_cnt = n_cnt;
         m_mode = n_mode; m_guard = n_guard; m_pin = rst_pin;
      end
   end

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge osc_clk) begin
      cyc++;
      if (por_n) begin
         check("R1 phase", phase_o, m_phase);
         check("R2 state", state_o, m_state);
         check("R3 cpu_clk_en", cpu_clk_en, (m_mode == 0) && m_phase == 1);
         check("R3 per_clk_en", per_clk_en, (m_mode <= 1) && m_phase == 1);
         check("R5 osc_run", osc_run, m_mode != 2);
         check("R7 core_rst", core_rst, m_core);
         check("R8 ram_wr_block", ram_wr_block, m_guard);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge osc_clk);
   endtask

   task automatic pulse_req(bit idl, bit pd);
      @(negedge osc_clk); idle_set = idl; pd_set = pd;
      @(negedge osc_clk); idle_set = 0; pd_set = 0;
   endtask

   bit done = 0;
   initial begin
      while (!done && cyc < 100000) @(negedge osc_clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int seen, cnt;
      step(3);
      check("R2 reset state", state_o, 0);
      check("R7 reset core_rst", core_rst, 1);
      check("R1 reset phase", phase_o, 0);
      por_n = 1;
      step(2);
      check("R7 core_rst released", core_rst, 0);
      // R2: one machine cycle is 12 oscillator periods
      while (!(state_o == 5 && phase_o)) @(negedge osc_clk);
      cnt = 0;
      do begin @(negedge osc_clk); cnt++; end while (!(state_o == 5 && phase_o));
      check("R2 machine cycle length", cnt, 12);
      // R10 / R3: idle
      pulse_req(1, 0);
      seen = 0; cnt = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge osc_clk); seen += cpu_clk_en; cnt += per_clk_en;
      end
      check("R3 cpu stopped in idle", seen, 0);
      check("R3 periph pulses in idle", cnt, 10);
      pulse_req(0, 1);
      check("R9 pd ignored in idle", osc_run, 1);
      // R4: interrupt exit
      @(negedge osc_clk); irq_pending = 1;
      @(negedge osc_clk); irq_pending = 0;
      step(2);
      check("R4 running after irq", cpu_clk_en | cpu_clk_en === 1'b0 ? per_clk_en == cpu_clk_en : 0, 1);
      // R9: both requests -> power-down
      pulse_req(1, 1);
      check("R9 both requests give power-down", osc_run, 0);
      cnt = state_o;
      irq_pending = 1; step(50); irq_pending = 0;
      check("R5 frozen state", state_o, cnt);
      check("R5 irq ignored", osc_run, 0);
      // R6: short pin pulse wakes then returns
      rst_pin = 1; step(10);
      check("R6 oscillator restarted", osc_run, 1);
      check("R6 cpu held", cpu_clk_en, 0);
      rst_pin = 0; step(4);
      check("R6 back to power-down", osc_run, 0);
      // R7: long pin high
      rst_pin = 1; step(45);
      check("R7 qualified reset", core_rst, 1);
      rst_pin = 0; step(3);
      check("R7 reset released", core_rst, 0);
      check("R6 running after reset", osc_run, 1);
      // R7: glitch restarts the count
      rst_pin = 1; step(20); rst_pin = 0; step(1); rst_pin = 1; step(23);
      check("R7 glitch restarts count", core_rst, 0);
      step(20);
      check("R7 qualified after glitch", core_rst, 1);
      pulse_req(0, 1);
      check("R9 request ignored in reset", osc_run, 1);
      rst_pin = 0; step(3);
      // R8: idle ended by reset, pin dropped early
      pulse_req(1, 0);
      rst_pin = 1; step(4);
      check("R8 guard raised", ram_wr_block, 1);
      rst_pin = 0; step(3);
      check("R8 guard cleared by pin low", ram_wr_block, 0);
      // R8: idle ended by reset held long
      pulse_req(1, 0);
      rst_pin = 1; step(45);
      check("R8 guard cleared by reset", ram_wr_block, 0);
      check("R8 core reset taken", core_rst, 1);
      rst_pin = 0; step(5);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule